// File: doc/BRIEF.md
# Trigger-Positioned Capture Buffer

This block keeps a circular memory of qualified samples. It stores samples continuously while it waits for a trigger. After the trigger it stores a programmed number of further samples and then stops. The effect is that the trigger sample ends up at a chosen place in the captured window. That place can be near the oldest entry, in the middle, at the newest entry, or at a pre-trigger depth set by software.

A sequencer outside this block decides, one sample at a time, whether a sample is worth keeping. It drives a global default store enable and a per-level override that replaces the default when it is active. Every stored entry carries a time tag. The tag counts the valid samples since the previous stored entry, including the entry's own sample, so stretches of unstored samples stay visible. The tag saturates and does not wrap.

Once capture completes, `done` rises and writes stop. The trigger's physical address, the oldest valid address and the entry count are then reported. A read port returns entries by chronological index, with index 0 being the oldest.

The controller has four states: IDLE (after reset), PRE (filling, waiting for a trigger), POST (counting post-trigger stores) and DONE (frozen, readable). The transitions are:
- ARM_START: IDLE→PRE.
- TRIG_TO_POST: PRE→POST, taken when post-trigger entries remain.
- TRIG_TO_DONE: PRE→DONE, taken when the trigger sample completes the window.
- POST_FULL: POST→DONE, taken on the last post-trigger store.
- REARM: any state to PRE when `arm` is high.

Top module: `trig_capture_buf`

## Requirements
- R1: After reset `done` is 0 and `entry_cnt` is 0, and no entry is written until `arm` is pulsed.
- R2: The pre-trigger depth P follows `pos_sel`: 0 gives P=0, 1 gives P=DEPTH/2, 2 gives P=DEPTH-1 and 3 gives P=`user_pre`. Capture ends on the store that makes DEPTH-P entries counted from the trigger sample inclusive.
- R3: The trigger sample is always stored, whatever the qualification inputs say. `trig_addr` gives its physical address. Physical addresses count up from 0 at arm, one per stored entry, modulo DEPTH.
- R4: A valid sample that is not the trigger is stored when `lvl_ovr`=1 and `lvl_store`=1. When `lvl_ovr`=0 it is stored when `dflt_store`=1. In every other case it is not stored.
- R5: A stored entry's tag equals the number of valid samples since the previous stored entry (or since arm), counting its own sample. The tag saturates at 2^TAG_W-1.
- R6: `entry_cnt` is the number of stored entries, limited to DEPTH. `start_addr` is 0 until the buffer has wrapped, and after that it is the oldest entry's address. A trigger that arrives before P entries exist still completes capture.
- R7: After `done` rises, further samples and triggers change nothing. `rd_data`/`rd_tag` return the entry at chronological index `rd_idx` one clock after `rd_idx` is applied.
- R8: `smp_trig` acts only together with `smp_valid` and only in PRE. A trigger without valid, or a trigger during POST, is ignored.
- R9: `arm` restarts capture from any state: it clears `done`, the write address, the count and the tag gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Start or restart a capture |
| pos_sel | input | 2 | Trigger position select |
| user_pre | input | ADDR_W | Pre-trigger depth for user position |
| smp_data | input | DATA_W | Sample data |
| smp_valid | input | 1 | Sample present this clock |
| smp_trig | input | 1 | Trigger strobe |
| dflt_store | input | 1 | Global default store enable |
| lvl_ovr | input | 1 | Level qualification overrides default |
| lvl_store | input | 1 | Level store decision |
| rd_idx | input | ADDR_W | Chronological read index |
| done | output | 1 | Capture complete |
| trig_addr | output | ADDR_W | Physical address of trigger entry |
| start_addr | output | ADDR_W | Physical address of oldest entry |
| entry_cnt | output | ADDR_W+1 | Number of valid entries |
| rd_data | output | DATA_W | Read data |
| rd_tag | output | TAG_W | Read time tag |

## Verification
The assertions rely on three properties of the inputs. DEPTH is a power of two. `user_pre` never exceeds DEPTH-1, and that bound holds by its width. `arm` takes priority over any sample presented in the same clock. The stimulus therefore keeps `smp_valid` low while it pulses `arm`, except in the re-arm test, where the arm cycle is deliberately idle. The stimulus changes `rd_idx` only after `done` has risen, so reads see a frozen memory.

// File: rtl/cbuf_pkg.sv
package cbuf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRE  = 2'd1,
        ST_POST = 2'd2,
        ST_DONE = 2'd3
    } cap_state_t;

    typedef enum logic [1:0] {
        POS_START  = 2'd0,
        POS_CENTER = 2'd1,
        POS_END    = 2'd2,
        POS_USER   = 2'd3
    } trig_pos_t;
endpackage

// File: rtl/cbuf_qual.sv
module cbuf_qual #(
    parameter int TAG_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             active,
    input  logic             smp_valid,
    input  logic             force_store,
    input  logic             dflt_store,
    input  logic             lvl_ovr,
    input  logic             lvl_store,
    output logic             store,
    output logic [TAG_W-1:0] tag
);
    localparam logic [TAG_W-1:0] TAG_MAX = '1;

    logic [TAG_W-1:0] gap;
    logic             qual;

    always_comb begin
        qual  = lvl_ovr ? lvl_store : dflt_store;
        store = active && smp_valid && (force_store || qual);
        tag   = (gap == TAG_MAX) ? TAG_MAX : gap + TAG_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || arm) begin
            gap <= '0;
        end else if (active && smp_valid) begin
            gap <= store ? '0 : tag;
        end
    end

    // R5: every stored entry counts at least its own sample
    a_r5_tag_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        store |-> (tag != '0));
endmodule

// File: rtl/cbuf_mem.sv
module cbuf_mem #(
    parameter int DATA_W = 8,
    parameter int TAG_W  = 10,
    parameter int DEPTH  = 16,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [TAG_W-1:0]  wtag,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata,
    output logic [TAG_W-1:0]  rtag
);
    logic [DATA_W-1:0] data_ram [DEPTH];
    logic [TAG_W-1:0]  tag_ram  [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            data_ram[waddr] <= wdata;
            tag_ram[waddr]  <= wtag;
        end
        rdata <= data_ram[raddr];
        rtag  <= tag_ram[raddr];
    end

    // R7: memory is frozen once capture completes
    a_r7_no_write_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !we);
endmodule

// File: rtl/cbuf_ctrl.sv
module cbuf_ctrl
    import cbuf_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int CNT_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic [1:0]        pos_sel,
    input  logic [ADDR_W-1:0] user_pre,
    input  logic              smp_valid,
    input  logic              smp_trig,
    input  logic              store,
    output logic              active,
    output logic              trig_hit,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              done,
    output logic [ADDR_W-1:0] trig_addr,
    output logic [ADDR_W-1:0] start_addr,
    output logic [CNT_W-1:0]  entry_cnt
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    cap_state_t        state, state_nx;
    logic [ADDR_W-1:0] wr_ptr;
    logic [CNT_W-1:0]  fill;
    logic [CNT_W-1:0]  post_left;
    logic [CNT_W-1:0]  pre_cnt;
    logic [CNT_W-1:0]  post_init;
    logic [ADDR_W-1:0] trig_q;

    always_comb begin
        unique case (trig_pos_t'(pos_sel))
            POS_START:  pre_cnt = '0;
            POS_CENTER: pre_cnt = CNT_W'(DEPTH / 2);
            POS_END:    pre_cnt = CNT_W'(DEPTH - 1);
            POS_USER:   pre_cnt = {1'b0, user_pre};
        endcase
        post_init = FULL - pre_cnt - CNT_W'(1);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (arm) state_nx = ST_PRE;
            ST_PRE: begin
                if (arm)           state_nx = ST_PRE;
                else if (trig_hit) state_nx = (post_init == '0) ? ST_DONE : ST_POST;
            end
            ST_POST: begin
                if (arm)                                       state_nx = ST_PRE;
                else if (store && post_left == CNT_W'(1))      state_nx = ST_DONE;
            end
            ST_DONE: if (arm) state_nx = ST_PRE;
        endcase
    end

    // outputs
    always_comb begin
        active     = ((state == ST_PRE) || (state == ST_POST)) && !arm;
        trig_hit   = (state == ST_PRE) && !arm && smp_valid && smp_trig;
        done       = (state == ST_DONE);
        wr_addr    = wr_ptr;
        trig_addr  = trig_q;
        entry_cnt  = fill;
        start_addr = (fill == FULL) ? wr_ptr : '0;
    end

    // pointers and counters
    always_ff @(posedge clk) begin
        if (!rst_n || arm) begin
            wr_ptr    <= '0;
            fill      <= '0;
            post_left <= '0;
            trig_q    <= '0;
        end else if (store) begin
            wr_ptr <= wr_ptr + ADDR_W'(1);
            if (fill != FULL) fill <= fill + CNT_W'(1);
            if (trig_hit) begin
                trig_q    <= wr_ptr;
                post_left <= post_init;
            end else if (state == ST_POST) begin
                post_left <= post_left - CNT_W'(1);
            end
        end
    end

    // R2: POST always has entries left to take
    a_r2_post_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_POST) |-> (post_left != '0));
    // R6: count never exceeds the depth
    a_r6_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= FULL);
    // R9: arm always lands in PRE
    a_r9_arm_rearms: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (state == ST_PRE));
    // R3: trigger address held while frozen
    a_r3_trig_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(done)) |-> $stable(trig_q));
endmodule

// File: rtl/trig_capture_buf.sv
module trig_capture_buf #(
    parameter int DATA_W = 8,
    parameter int TAG_W  = 10,
    parameter int DEPTH  = 16,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic [1:0]        pos_sel,
    input  logic [ADDR_W-1:0] user_pre,
    input  logic [DATA_W-1:0] smp_data,
    input  logic              smp_valid,
    input  logic              smp_trig,
    input  logic              dflt_store,
    input  logic              lvl_ovr,
    input  logic              lvl_store,
    input  logic [ADDR_W-1:0] rd_idx,
    output logic              done,
    output logic [ADDR_W-1:0] trig_addr,
    output logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W:0]   entry_cnt,
    output logic [DATA_W-1:0] rd_data,
    output logic [TAG_W-1:0]  rd_tag
);
    logic              active;
    logic              trig_hit;
    logic              store;
    logic [TAG_W-1:0]  tag;
    logic [ADDR_W-1:0] wr_addr;
    logic [ADDR_W-1:0] rd_addr;

    assign rd_addr = start_addr + rd_idx;

    cbuf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .arm(arm),
        .pos_sel(pos_sel), .user_pre(user_pre),
        .smp_valid(smp_valid), .smp_trig(smp_trig), .store(store),
        .active(active), .trig_hit(trig_hit), .wr_addr(wr_addr),
        .done(done), .trig_addr(trig_addr), .start_addr(start_addr),
        .entry_cnt(entry_cnt)
    );

    cbuf_qual #(.TAG_W(TAG_W)) u_qual (
        .clk(clk), .rst_n(rst_n), .arm(arm), .active(active),
        .smp_valid(smp_valid), .force_store(trig_hit),
        .dflt_store(dflt_store), .lvl_ovr(lvl_ovr), .lvl_store(lvl_store),
        .store(store), .tag(tag)
    );

    cbuf_mem #(.DATA_W(DATA_W), .TAG_W(TAG_W), .DEPTH(DEPTH)) u_mem (
        .clk(clk), .rst_n(rst_n), .done(done),
        .we(store), .waddr(wr_addr), .wdata(smp_data), .wtag(tag),
        .raddr(rd_addr), .rdata(rd_data), .rtag(rd_tag)
    );
endmodule

// File: tb/tb_trig_capture_buf.sv
module tb_trig_capture_buf;
    localparam int DATA_W = 8;
    localparam int TAG_W  = 10;
    localparam int DEPTH  = 16;
    localparam int ADDR_W = 4;
    localparam int TMAX   = (1 << TAG_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic arm = 1'b0;
    logic [1:0] pos_sel = '0;
    logic [ADDR_W-1:0] user_pre = '0;
    logic [DATA_W-1:0] smp_data = '0;
    logic smp_valid = 1'b0, smp_trig = 1'b0;
    logic dflt_store = 1'b0, lvl_ovr = 1'b0, lvl_store = 1'b0;
    logic [ADDR_W-1:0] rd_idx = '0;
    logic done;
    logic [ADDR_W-1:0] trig_addr, start_addr;
    logic [ADDR_W:0] entry_cnt;
    logic [DATA_W-1:0] rd_data;
    logic [TAG_W-1:0] rd_tag;

    always #2 clk = ~clk;

    trig_capture_buf #(.DATA_W(DATA_W), .TAG_W(TAG_W), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .arm(arm), .pos_sel(pos_sel), .user_pre(user_pre),
        .smp_data(smp_data), .smp_valid(smp_valid), .smp_trig(smp_trig),
        .dflt_store(dflt_store), .lvl_ovr(lvl_ovr), .lvl_store(lvl_store),
        .rd_idx(rd_idx), .done(done), .trig_addr(trig_addr), .start_addr(start_addr),
        .entry_cnt(entry_cnt), .rd_data(rd_data), .rd_tag(rd_tag)
    );

    int n_cmp = 0;
    int n_bad = 0;

    // reference model state
    int m_d[$];
    int m_t[$];
    int m_gap, m_phase, m_post, m_pre, m_trig;
    // scoreboard queues
    int exp_d[$];
    int exp_t[$];

    task automatic check(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_arm(int mode, int upre);
        pos_sel  = 2'(mode);
        user_pre = ADDR_W'(upre);
        case (mode)
            0: m_pre = 0;
            1: m_pre = DEPTH / 2;
            2: m_pre = DEPTH - 1;
            default: m_pre = upre;
        endcase
        m_d.delete(); m_t.delete();
        m_gap = 0; m_phase = 0; m_post = 0; m_trig = 0;
        smp_valid = 1'b0; smp_trig = 1'b0;
        arm = 1'b1;
        @(negedge clk);
        arm = 1'b0;
    endtask

    // driver: applies one sample and advances the model
    task automatic smp(int d, bit v, bit t, bit df, bit ov, bit os);
        bit st;
        int g;
        smp_data = DATA_W'(d); smp_valid = v; smp_trig = t;
        dflt_store = df; lvl_ovr = ov; lvl_store = os;
        if (v && m_phase != 2) begin
            st = (m_phase == 0 && t) || (ov ? os : df);
            g = (m_gap >= TMAX) ? TMAX : m_gap + 1;
            if (st) begin
                m_d.push_back(d); m_t.push_back(g); m_gap = 0;
                if (m_phase == 0 && t) begin
                    m_trig = m_d.size() - 1;
                    m_post = DEPTH - m_pre - 1;
                    m_phase = (m_post == 0) ? 2 : 1;
                end else if (m_phase == 1) begin
                    m_post--;
                    if (m_post == 0) m_phase = 2;
                end
            end else begin
                m_gap = g;
            end
        end
        @(negedge clk);
        smp_valid = 1'b0; smp_trig = 1'b0;
    endtask

    // monitor: reads the port in chronological order and compares with the queue
    task automatic monitor(string req, int cnt);
        for (int i = 0; i < cnt; i++) begin
            int ed, et;
            rd_idx = ADDR_W'(i);
            @(negedge clk);
            ed = exp_d.pop_front();
            et = exp_t.pop_front();
            check({req, " data"}, int'(rd_data), ed);
            check({req, " tag"}, int'(rd_tag), et);
        end
    endtask

    task automatic finish_run(string req);
        int sz, cnt;
        sz  = m_d.size();
        cnt = (sz > DEPTH) ? DEPTH : sz;
        check({req, " done"}, int'(done), (m_phase == 2) ? 1 : 0);
        check({req, " trig_addr R3"}, int'(trig_addr), m_trig % DEPTH);
        check({req, " entry_cnt R6"}, int'(entry_cnt), cnt);
        check({req, " start_addr R6"}, int'(start_addr), (sz >= DEPTH) ? sz % DEPTH : 0);
        for (int i = sz - cnt; i < sz; i++) begin
            exp_d.push_back(m_d[i]);
            exp_t.push_back(m_t[i]);
        end
        // R7: activity after done must leave the buffer untouched
        for (int i = 0; i < 4; i++) smp(200 + i, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
        check({req, " R7 entry_cnt frozen"}, int'(entry_cnt), cnt);
        monitor(req, cnt);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got 1 expected 0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 done", int'(done), 0);
        check("R1 entry_cnt", int'(entry_cnt), 0);
        smp(9, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
        check("R1 no store before arm", int'(entry_cnt), 0);

        // R2 end position, R8 trigger without valid ignored
        do_arm(2, 0);
        for (int i = 0; i < 20; i++) begin
            if (i == 5) begin
                smp(77, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
                check("R8 trig without valid", int'(done), 0);
            end
            smp(i, 1'b1, i == 19, 1'b1, 1'b0, 1'b0);
        end
        finish_run("R2 end");

        // R2 start position, R8 trigger during POST ignored
        do_arm(0, 0);
        for (int i = 0; i < 30; i++)
            smp(i + 40, (i % 4) != 3, (i == 2) || (i == 8), 1'b1, 1'b0, 1'b0);
        finish_run("R2 start R8");

        // R4 override patterns, R6 early trigger with center position
        do_arm(1, 0);
        for (int i = 0; i < 60; i++)
            smp(i, (i % 5) != 4, i == 10, 1'b0, (i % 3) != 2, (i % 3) == 0);
        finish_run("R4 R6 center");

        // R2 user position, R5 saturation, R3 trigger stored against qualification
        do_arm(3, 5);
        for (int i = 0; i < 8; i++) smp(i, 1'b1, 1'b0, 1'b1, i[0], 1'b0);
        for (int i = 0; i < 1100; i++) smp(i & 255, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        smp(123, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 12; i++) smp(i + 130, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        check("R5 saturated tag in model", m_t[m_trig], TMAX);
        finish_run("R2 user R5 R3");

        // R9 re-arm in the middle of POST
        do_arm(0, 0);
        smp(1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
        smp(2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        do_arm(1, 0);
        check("R9 entry_cnt cleared", int'(entry_cnt), 0);
        check("R9 done low", int'(done), 0);
        for (int i = 0; i < 24; i++) smp(i + 90, 1'b1, i == 12, 1'b1, 1'b0, 1'b0);
        finish_run("R9 rearm");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule